// File: doc/BRIEF.md
# ADC Serial Result Output with Tag Chaining

This block sends a converter's latched result word out of one serial data pin, most significant bit first. The word can go out as straight binary or as two's complement. A single mode pin picks the bit clock. In internal-clock mode the block divides the system clock down and drives a burst of exactly one pulse per result bit on its own clock output, and it starts the burst from the convert command. In external-clock mode the host supplies the bit clock, a read window opens the transfer, and a SYNC pulse marks the first bit.

In external-clock mode a tag input is carried through a delay line as long as the bit count, and its output follows the result on the data pin. Several converters can therefore be chained, each one's data pin feeding the next one's tag input, and read as one long word. The sequencer's result strobe loads a shadow register, and every transfer sends the shadow content held at its trigger. A conversion that finishes during a transfer cannot corrupt the bits already in flight.

Top module: `adc_serial_out`

## Requirements
- R1: With `fmt_sb` high the word goes out unchanged (straight binary). With `fmt_sb` low its MSB is inverted (two's complement). Bits always leave MSB first.
- R2: In internal mode (`ext_mode` low) a falling edge of (`cs_n` OR `rd_conv`) starts a transfer. `dclk_out` then gives exactly 16 pulses, each lasting 4*QTR system clocks, and stays low afterwards.
- R3: In internal mode each data bit is steady across both the rising and the falling edge of its `dclk_out` pulse.
- R4: In internal mode, outside a transfer, `sdata_out` equals the `tag_in` level sampled at the convert command, whatever `tag_in` does later.
- R5: In external mode `dclk_out` stays low. A rise of (`cs_n` low AND `rd_conv` high) starts a transfer, whether it comes from an `rd_conv` rise or a `cs_n` fall. `sync_out` goes high at the start and drops at the first falling edge of `dclk_in`, and the MSB is on `sdata_out` from the start.
- R6: In external mode `sdata_out` moves to the next bit on each falling edge of `dclk_in`. A receiver samples it on the rising edges.
- R7: In external mode, after the 16 result bits, `sdata_out` presents the `tag_in` values taken at `dclk_in` rising edges, each appearing 16 rising edges after it was taken.
- R8: In external mode `sdata_out` and `sync_out` are low while the read window (`cs_n` low and `rd_conv` high) is closed.
- R9: A `res_valid` strobe loads `res_data` into a shadow register. A transfer sends the shadow value present at its trigger, unaffected by later strobes.
- R10: After reset `dclk_out`, `sync_out` and `sdata_out` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| res_data | input | DATA_W | Conversion result from the sequencer, straight binary |
| res_valid | input | 1 | One-cycle strobe marking `res_data` valid |
| cs_n | input | 1 | Chip select, active low |
| rd_conv | input | 1 | Read/convert control |
| ext_mode | input | 1 | High: external bit clock; low: internal bit clock |
| fmt_sb | input | 1 | High: straight binary; low: two's complement |
| tag_in | input | 1 | Chain input from an upstream converter |
| dclk_in | input | 1 | External bit clock, used in external mode |
| dclk_out | output | 1 | Generated bit clock, used in internal mode |
| sdata_out | output | 1 | Serial data |
| sync_out | output | 1 | Transfer-start marker in external mode |

## Verification
Most internal faults here show on the pins within one transfer. A wrong bit counter or a wrong divider phase shows as a pulse count other than 16, or as a period other than 4*QTR, before the idle level returns. A mis-timed data shift shows as a word whose rising-edge and falling-edge samples differ. Shadow or format faults show as a wrong first bit. A tag delay line of the wrong length shows only after the 16th external pulse, as chained bits shifted by one or more places.

// File: rtl/aso_pkg.sv
// Shared types for the serial result output.
// Assumes: nothing beyond IEEE 1800-2017.
package aso_pkg;

    // Transmitter state for the internally clocked burst.
    typedef enum logic [0:0] {
        TX_IDLE = 1'b0,
        TX_SEND = 1'b1
    } tx_state_t;

    // Meaning of the format select pin.
    typedef enum logic {
        FMT_TWOS     = 1'b0,
        FMT_STRAIGHT = 1'b1
    } fmt_sel_t;

endpackage

// File: rtl/aso_dclk_sync.sv
// Brings the external bit clock into the system clock domain and flags its edges.
// Assumes: the external clock's high and low phases each last well over
// SYNC_STAGES+1 system clocks.
module aso_dclk_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dclk_in,
    output logic dclk_rise,
    output logic dclk_fall
);
    localparam int DEPTH = SYNC_STAGES + 1;

    logic [DEPTH-1:0] pipe;

    // Synchronizer chain plus one history stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe <= '0;
        end else begin
            pipe <= {pipe[DEPTH-2:0], dclk_in};
        end
    end

    assign dclk_rise =  pipe[DEPTH-2] && !pipe[DEPTH-1];
    assign dclk_fall = !pipe[DEPTH-2] &&  pipe[DEPTH-1];

endmodule

// File: rtl/aso_int_tx.sv
// Internally clocked transmitter: a divider makes a 16-pulse (DATA_W) burst.
// Data changes only a quarter period before each rising edge, while the clock
// is low, so both edges of a pulse see the same bit. When idle it drives the
// tag level captured at the convert command.
// Assumes: start is a one-cycle pulse; en low aborts and idles.
module aso_int_tx
    import aso_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int QTR    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              start,
    input  logic [DATA_W-1:0] word,
    input  logic              tag_in,
    output logic              dclk,
    output logic              sd
);
    localparam int PER = 4 * QTR;
    localparam int PW  = (PER > 1) ? $clog2(PER) : 1;
    localparam int CW  = $clog2(DATA_W);

    tx_state_t          st;
    logic [PW-1:0]      phase;
    logic [CW-1:0]      bit_cnt;
    logic [DATA_W-1:0]  shreg;
    logic               tag_hold;

    // Burst sequencer: phase divider, bit counter, shift register, tag capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= TX_IDLE;
            phase    <= '0;
            bit_cnt  <= '0;
            shreg    <= '0;
            tag_hold <= 1'b0;
        end else if (!en) begin
            st       <= TX_IDLE;
        end else if (start) begin
            st       <= TX_SEND;
            phase    <= '0;
            bit_cnt  <= '0;
            shreg    <= word;
            tag_hold <= tag_in;
        end else if (st == TX_SEND) begin
            if (phase == PW'(PER - 1)) begin
                phase <= '0;
                if (bit_cnt == CW'(DATA_W - 1)) begin
                    st <= TX_IDLE;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                    shreg   <= {shreg[DATA_W-2:0], 1'b0};
                end
            end else begin
                phase <= phase + 1'b1;
            end
        end
    end

    assign dclk = (st == TX_SEND) && (phase >= PW'(QTR)) && (phase < PW'(3 * QTR));
    assign sd   = (st == TX_SEND) ? shreg[DATA_W-1] : tag_hold;

    // Checker state: rising edges of dclk since the last start.
    logic [CW:0] chk_rises;
    logic        chk_dclk_d;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_rises  <= '0;
            chk_dclk_d <= 1'b0;
        end else begin
            chk_dclk_d <= dclk;
            if (start) begin
                chk_rises <= '0;
            end else if (dclk && !chk_dclk_d && (chk_rises != '1)) begin
                chk_rises <= chk_rises + 1'b1;
            end
        end
    end

    AST_BURST_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        chk_rises <= (CW+1)'(DATA_W)); // R2
    AST_BIT_STEADY_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($rose(dclk) || $fell(dclk))) |-> $stable(sd)); // R3
    AST_IDLE_TAG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && st == TX_IDLE && $past(st == TX_IDLE) && !$past(start)) |-> $stable(sd)); // R4

endmodule

// File: rtl/aso_ext_tx.sv
// Externally clocked transmitter with tag delay line. On start it raises
// sync and presents the MSB. Each external falling edge moves to the next bit;
// after DATA_W bits it presents the tag delay line output. The delay line
// shifts on every external rising edge.
// Assumes: win is the read window level; start is its rising edge.
module aso_ext_tx #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              win,
    input  logic              start,
    input  logic              dclk_rise,
    input  logic              dclk_fall,
    input  logic [DATA_W-1:0] word,
    input  logic              tag_in,
    output logic              sd,
    output logic              sync
);
    localparam int CW = $clog2(DATA_W + 1);

    logic [DATA_W-1:0] shreg;
    logic [DATA_W-1:0] tag_line;
    logic [CW-1:0]     fe_cnt;
    logic              dq;
    logic              busy;
    logic              sync_q;

    // Transfer control: load on start, advance on falling edges, stop on window close.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg  <= '0;
            fe_cnt <= '0;
            dq     <= 1'b0;
            busy   <= 1'b0;
            sync_q <= 1'b0;
        end else if (!en) begin
            busy   <= 1'b0;
            sync_q <= 1'b0;
        end else if (start) begin
            shreg  <= {word[DATA_W-2:0], 1'b0};
            dq     <= word[DATA_W-1];
            fe_cnt <= '0;
            busy   <= 1'b1;
            sync_q <= 1'b1;
        end else if (!win) begin
            busy   <= 1'b0;
            sync_q <= 1'b0;
        end else if (busy && dclk_fall) begin
            sync_q <= 1'b0;
            dq     <= (fe_cnt < CW'(DATA_W - 1)) ? shreg[DATA_W-1] : tag_line[DATA_W-1];
            shreg  <= {shreg[DATA_W-2:0], 1'b0};
            if (fe_cnt != CW'(DATA_W)) begin
                fe_cnt <= fe_cnt + 1'b1;
            end
        end
    end

    // Tag delay line: one stage per result bit, shifted on external rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_line <= '0;
        end else if (en && dclk_rise) begin
            tag_line <= {tag_line[DATA_W-2:0], tag_in};
        end
    end

    assign sd   = busy && dq;
    assign sync = sync_q;

    AST_SYNC_ONLY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(sync)) |-> $past(start)); // R5
    AST_CLOSED_WINDOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && en && $past(en) && !win && $past(!win)) |-> (!sd && !sync)); // R8

endmodule

// File: rtl/adc_serial_out.sv
// Top of the serial result output. Holds the shadow result, applies the
// output format, decodes the convert and read triggers from the control pins,
// and selects between the internal and external transmitters.
// Assumes: cs_n, rd_conv, res_valid and the mode pins are synchronous to clk.
// Mode pins change only between transfers.
module adc_serial_out
    import aso_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int QTR         = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] res_data,
    input  logic              res_valid,
    input  logic              cs_n,
    input  logic              rd_conv,
    input  logic              ext_mode,
    input  logic              fmt_sb,
    input  logic              tag_in,
    input  logic              dclk_in,
    output logic              dclk_out,
    output logic              sdata_out,
    output logic              sync_out
);
    logic [DATA_W-1:0] shadow;
    logic [DATA_W-1:0] fmt_word;
    logic              conv_n, conv_q, win, win_q;
    logic              int_start, ext_start;
    logic              dclk_rise, dclk_fall;
    logic              int_dclk, int_sd, ext_sd, ext_sync;

    // Shadow result: loaded only by the sequencer strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= '0;
        end else if (res_valid) begin
            shadow <= res_data;
        end
    end

    // Output format: two's complement is straight binary with the MSB inverted.
    always_comb begin
        fmt_word = shadow;
        if (fmt_sel_t'(fmt_sb) == FMT_TWOS) begin
            fmt_word[DATA_W-1] = ~shadow[DATA_W-1];
        end
    end

    // Trigger history: both levels reset high so reset release makes no edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_q <= 1'b1;
            win_q  <= 1'b1;
        end else begin
            conv_q <= conv_n;
            win_q  <= win;
        end
    end

    assign conv_n    = cs_n | rd_conv;
    assign win       = !cs_n && rd_conv;
    assign int_start = !ext_mode && !conv_n && conv_q;
    assign ext_start =  ext_mode && win && !win_q;

    aso_dclk_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .dclk_in   (dclk_in),
        .dclk_rise (dclk_rise),
        .dclk_fall (dclk_fall)
    );

    aso_int_tx #(
        .DATA_W (DATA_W),
        .QTR    (QTR)
    ) u_int (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (!ext_mode),
        .start  (int_start),
        .word   (fmt_word),
        .tag_in (tag_in),
        .dclk   (int_dclk),
        .sd     (int_sd)
    );

    aso_ext_tx #(
        .DATA_W (DATA_W)
    ) u_ext (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (ext_mode),
        .win       (win),
        .start     (ext_start),
        .dclk_rise (dclk_rise),
        .dclk_fall (dclk_fall),
        .word      (fmt_word),
        .tag_in    (tag_in),
        .sd        (ext_sd),
        .sync      (ext_sync)
    );

    assign dclk_out  = int_dclk;
    assign sdata_out = ext_mode ? ext_sd : int_sd;
    assign sync_out  = ext_sync;

    AST_SHADOW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(res_valid)) |-> (shadow == $past(res_data))); // R9
    AST_NO_CLOCK_IN_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ext_mode && $past(ext_mode)) |-> !dclk_out); // R5
    AST_FIRST_BIT_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ext_start)) |-> (sdata_out == ($past(shadow[DATA_W-1]) ^ !$past(fmt_sb)))); // R1

endmodule

// File: tb/tb_adc_serial_out.sv
module tb_adc_serial_out;
    localparam int W   = 16;
    localparam int Q   = 2;
    localparam int PER = 4 * Q;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  res_data = '0;
    logic          res_valid = 1'b0;
    logic          cs_n = 1'b1;
    logic          rd_conv = 1'b1;
    logic          ext_mode = 1'b0;
    logic          fmt_sb = 1'b1;
    logic          tag_in = 1'b0;
    logic          dclk_in = 1'b0;
    logic          dclk_out, sdata_out, sync_out;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    adc_serial_out #(.DATA_W(W), .QTR(Q), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .res_data(res_data), .res_valid(res_valid),
        .cs_n(cs_n), .rd_conv(rd_conv), .ext_mode(ext_mode), .fmt_sb(fmt_sb),
        .tag_in(tag_in), .dclk_in(dclk_in), .dclk_out(dclk_out),
        .sdata_out(sdata_out), .sync_out(sync_out)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load(input logic [W-1:0] w);
        res_data = w; res_valid = 1'b1; tick(1); res_valid = 1'b0; tick(1);
    endtask

    // Internal-mode transfer of the current shadow word w, watched at the pins.
    task automatic int_xfer(input logic sb, input logic tg, input logic [W-1:0] w,
                            input logic midload, input logic [W-1:0] w2);
        logic [W-1:0] exp, rw, fw;
        int rises, falls, t1, t2;
        logic prev;
        exp = sb ? w : {~w[W-1], w[W-2:0]};
        ext_mode = 1'b0; fmt_sb = sb; tag_in = tg; cs_n = 1'b0; rd_conv = 1'b1;
        tick(2);
        rd_conv = 1'b0;
        rises = 0; falls = 0; rw = '0; fw = '0; t1 = 0; t2 = 0; prev = 1'b0;
        for (int c = 0; c < W * PER + 16; c++) begin
            tick(1);
            if (c == 0) tag_in = ~tg;
            if (midload && c == 30) begin res_data = w2; res_valid = 1'b1; end
            if (c == 31) res_valid = 1'b0;
            if (dclk_out && !prev) begin
                rises++; rw = {rw[W-2:0], sdata_out};
                if (rises == 1) t1 = c;
                if (rises == 2) t2 = c;
            end
            if (!dclk_out && prev) begin
                falls++; fw = {fw[W-2:0], sdata_out};
            end
            prev = dclk_out;
        end
        chk("R2 pulse count", rises, W);
        chk("R2 period", t2 - t1, PER);
        chk("R1 word at rising edges", rw, exp);
        chk("R3 word at falling edges", fw, exp);
        chk("R4 idle tag level", sdata_out, tg);
        chk("R2 clock low after burst", dclk_out, 0);
        rd_conv = 1'b1;
        tick(2);
    endtask

    // External-mode read of shadow word w with a chained tag pattern (bits 1..4 used).
    task automatic ext_read(input logic sb, input logic [W-1:0] w, input logic by_cs,
                            input logic [31:0] tagv);
        logic [W-1:0] exp, got;
        logic [3:0]   tg;
        exp = sb ? w : {~w[W-1], w[W-2:0]};
        got = '0; tg = '0;
        ext_mode = 1'b1; fmt_sb = sb;
        tick(2);
        if (by_cs) begin
            rd_conv = 1'b1; cs_n = 1'b1; tick(2); cs_n = 1'b0;
        end else begin
            cs_n = 1'b0; rd_conv = 1'b0; tick(2); rd_conv = 1'b1;
        end
        tick(8);
        chk("R5 sync at start", sync_out, 1);
        chk("R5 no clock out", dclk_out, 0);
        for (int k = 1; k <= W + 4; k++) begin
            if (k == 2) chk("R5 sync dropped", sync_out, 0);
            if (k <= W) got = {got[W-2:0], sdata_out};
            else        tg  = {tg[2:0], sdata_out};
            tag_in = tagv[k];
            dclk_in = 1'b1; tick(8);
            dclk_in = 1'b0; tick(8);
        end
        chk("R6 external word", got, exp);
        chk("R7 chained tag bits", tg, {tagv[1], tagv[2], tagv[3], tagv[4]});
        cs_n = 1'b1;
        tick(3);
        chk("R8 data low when closed", sdata_out, 0);
        chk("R8 sync low when closed", sync_out, 0);
    endtask

    initial begin : wdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        logic [W-1:0] pats [6];
        pats[0] = 16'h0000; pats[1] = 16'hFFFF; pats[2] = 16'h8000;
        pats[3] = 16'h7FFF; pats[4] = 16'hA5C3; pats[5] = 16'h1234;
        tick(4);
        rst_n = 1'b1;
        tick(2);
        chk("R10 dclk_out reset", dclk_out, 0);
        chk("R10 sync_out reset", sync_out, 0);
        chk("R10 sdata_out reset", sdata_out, 0);

        // R1: pattern set in both formats, alternating tag levels.
        for (int i = 0; i < 6; i++) begin
            for (int f = 0; f < 2; f++) begin
                load(pats[i]);
                int_xfer(f[0], i[0] ^ f[0], pats[i], 1'b0, '0);
            end
        end
        // R1: walking one in two's complement.
        for (int b = 0; b < W; b++) begin
            load(W'(1) << b);
            int_xfer(1'b0, b[0], W'(1) << b, 1'b0, '0);
        end
        // R9: a strobe mid-transfer does not disturb it; the next transfer sends the new word.
        load(16'hC3A5);
        int_xfer(1'b1, 1'b1, 16'hC3A5, 1'b1, 16'h5A3C);
        int_xfer(1'b1, 1'b0, 16'h5A3C, 1'b0, '0);

        // External mode, both trigger forms and both formats.
        load(16'hB2D1);
        ext_read(1'b1, 16'hB2D1, 1'b0, 32'b1011_0);
        ext_read(1'b0, 16'hB2D1, 1'b1, 32'b0101_0);
        load(16'h0F0F);
        ext_read(1'b0, 16'h0F0F, 1'b0, 32'b1110_0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule